// File: doc/BRIEF.md
# Many-to-One Request Serializer

This block joins several upstream requesters to one shared downstream responder that can take only one request handshake at a time. Each upstream port offers requests with a valid/ready handshake. The block accepts at most one of them per cycle and places it in an internal queue. A forwarding state machine then presents the queued requests downstream one after another. When the responder holds off a request, every upstream port sees that pressure: the queue fills up, and acceptance stops for all ports together.

Every forwarded request gets a tag built from the originating port number and a wrapping sequence number. A routing table indexed by the sequence number remembers which port sent the request. The responder returns the tag with its response. The block uses the tag to steer the response to the recorded port. The downstream response completes only when that port accepts it.

The forwarding state machine has three states. FWD_IDLE means nothing is held. FWD_ISSUE means a request is presented downstream. FWD_BLOCKED means queued work exists but the routing slot for the next sequence number is still outstanding. It moves as follows:
- FWD_IDLE goes to FWD_ISSUE when the queue is non-empty and the slot is free.
- FWD_IDLE goes to FWD_BLOCKED when the queue is non-empty and the slot is busy.
- FWD_BLOCKED goes to FWD_ISSUE when the slot frees.
- After a downstream accept, FWD_ISSUE stays in FWD_ISSUE when the next request can be loaded at once. Otherwise it goes to FWD_BLOCKED when work is waiting, and to FWD_IDLE when the queue is empty.

Top module: `req_serializer`

## Requirements
- R1: After reset, `dn_req_valid` is 0 and `up_rsp_valid` is all zero. With no upstream valid, `up_req_ready` is all zero.
- R2: A request accepted upstream at clock edge E is presented on `dn_req_valid`/`dn_req_data` after edge E+1 when the forwarder is idle.
- R3: At most one upstream port is accepted per cycle. Among ports whose valid is high together, the grant goes to the first one found searching upward (with wrap) from the port after the last granted one. The search starts at port 0 after reset.
- R4: The internal queue holds 8 requests, with one more in the downstream holding register. When these are full, `up_req_ready` stays all zero whatever the upstream valids are.
- R5: While `dn_req_valid` is 1 and `dn_req_ready` is 0, the next cycle keeps `dn_req_valid` at 1 and `dn_req_data` and `dn_req_tag` unchanged.
- R6: Requests reach the downstream port in the order they were accepted upstream, one per downstream handshake. When work is queued, the next request is presented in the cycle right after a handshake.
- R7: `dn_req_tag` carries the port number in bits [TAG_W-1:SEQ_W] and a sequence number in bits [SEQ_W-1:0]. The sequence number is 0 for the first request after reset and goes up by 1, modulo 2^SEQ_W, per downstream handshake.
- R8: A response with `dn_rsp_valid` high is shown only on the `up_rsp_valid` bit of the port recorded for its tag's sequence number, with `up_rsp_data` equal to `dn_rsp_data`. In the same cycle, `dn_rsp_ready` equals that port's `up_rsp_ready`.
- R9: A sequence number's routing slot is freed by its response handshake. No request is forwarded with a sequence number whose slot is still outstanding, so `dn_req_valid` stays 0 until it frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | N_PORTS | Per-port request valid |
| up_req_data | input | N_PORTS*DATA_W | Per-port request payloads, port p at bits [p*DATA_W +: DATA_W] |
| up_req_ready | output | N_PORTS | Per-port request accept |
| up_rsp_valid | output | N_PORTS | Per-port response valid |
| up_rsp_data | output | DATA_W | Response payload shared by all ports |
| up_rsp_ready | input | N_PORTS | Per-port response accept |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_data | output | DATA_W | Downstream request payload |
| dn_req_tag | output | PORT_W+SEQ_W | Downstream request tag {port, sequence} |
| dn_req_ready | input | 1 | Downstream request accept |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_data | input | DATA_W | Downstream response payload |
| dn_rsp_tag | input | PORT_W+SEQ_W | Tag echoed with the response |
| dn_rsp_ready | output | 1 | Downstream response accept |

## Verification
The bench goes after the following corner cases, and what a faulty design would do in each:
- Simultaneous arrivals right after a grant to a middle port. A wrong pointer update would serve the ports out of the fair sequence, or would starve the port that was waiting.
- Saturation under a stalled responder. A queue that miscounts would accept a tenth request or overwrite a waiting one. A holding register that reloads would change the payload before the accept.
- All eight sequence numbers outstanding, with responses returned newest first. A design that ignores busy routing slots would reuse sequence 0 too early and misroute a response.
- A response stalled by one upstream port. A design that does not pass that port's accept back would drop or duplicate a response.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        FWD_IDLE    = 2'd0,
        FWD_ISSUE   = 2'd1,
        FWD_BLOCKED = 2'd2
    } fwd_state_e;

endpackage

// File: rtl/rs_rr_arbiter.sv
module rs_rr_arbiter #(
    parameter int N_REQ = 4,
    localparam int PW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    input  logic             advance,
    output logic [N_REQ-1:0] grant,
    output logic [PW-1:0]    grant_idx
);

    localparam logic [PW-1:0] LAST_IDX = PW'(N_REQ - 1);

    logic [PW-1:0] ptr_q;

    always_comb begin
        int  cand;
        logic found;
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int k = 0; k < N_REQ; k++) begin
            cand = (int'(ptr_q) + k) % N_REQ;
            if (!found && req[cand]) begin
                found       = 1'b1;
                grant[cand] = 1'b1;
                grant_idx   = PW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && (|req)) begin
            ptr_q <= (grant_idx == LAST_IDX) ? '0 : grant_idx + 1'b1;
        end
    end

    // R3: a single grant, and only to a requesting port
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

endmodule

// File: rtl/rs_req_fifo.sv
module rs_req_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    count_q;

    assign empty     = (count_q == '0);
    assign full      = (count_q == FULL_CNT);
    assign head_data = mem_q[rptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= (wptr_q == LAST_SLOT) ? '0 : wptr_q + 1'b1;
            end
            if (pop) begin
                rptr_q <= (rptr_q == LAST_SLOT) ? '0 : rptr_q + 1'b1;
            end
            if (push && !pop) begin
                count_q <= count_q + 1'b1;
            end else if (pop && !push) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wptr_q] <= push_data;
        end
    end

    // R4: the queue never takes a push while full
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R6: never pop from an empty queue
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/rs_route_table.sv
module rs_route_table #(
    parameter int PORT_W = 2,
    parameter int SEQ_W  = 3,
    localparam int SLOTS = 1 << SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [PORT_W-1:0] alloc_port,
    input  logic              release_en,
    input  logic [SEQ_W-1:0]  release_seq,
    input  logic [SEQ_W-1:0]  lookup_seq,
    output logic [PORT_W-1:0] lookup_port,
    output logic [SLOTS-1:0]  busy
);

    logic [SLOTS-1:0]  busy_q;
    logic [PORT_W-1:0] port_q [SLOTS];

    assign busy        = busy_q;
    assign lookup_port = port_q[lookup_seq];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[s] <= 1'b0;
                port_q[s] <= '0;
            end else if (alloc && (alloc_seq == SEQ_W'(s))) begin
                busy_q[s] <= 1'b1;
                port_q[s] <= alloc_port;
            end else if (release_en && (release_seq == SEQ_W'(s))) begin
                busy_q[s] <= 1'b0;
            end
        end
    end

    // R9: a slot is only taken when it is free
    p_alloc_free_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !busy_q[alloc_seq]);
    // R8: only outstanding slots are released
    p_release_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_en |-> busy_q[release_seq]);

endmodule

// File: rtl/req_serializer.sv
module req_serializer
    import rs_pkg::*;
#(
    parameter int N_PORTS   = 4,
    parameter int DATA_W    = 32,
    parameter int Q_DEPTH   = 8,
    parameter int SEQ_W     = 3,
    localparam int PORT_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int TAG_W    = PORT_W + SEQ_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          up_req_valid,
    input  logic [N_PORTS*DATA_W-1:0]   up_req_data,
    output logic [N_PORTS-1:0]          up_req_ready,
    output logic [N_PORTS-1:0]          up_rsp_valid,
    output logic [DATA_W-1:0]           up_rsp_data,
    input  logic [N_PORTS-1:0]          up_rsp_ready,
    output logic                        dn_req_valid,
    output logic [DATA_W-1:0]           dn_req_data,
    output logic [TAG_W-1:0]            dn_req_tag,
    input  logic                        dn_req_ready,
    input  logic                        dn_rsp_valid,
    input  logic [DATA_W-1:0]           dn_rsp_data,
    input  logic [TAG_W-1:0]            dn_rsp_tag,
    output logic                        dn_rsp_ready
);

    localparam int ENTRY_W = PORT_W + DATA_W;
    localparam int SLOTS   = 1 << SEQ_W;

    // upstream unpack and arbitration
    logic [DATA_W-1:0]  req_payload [N_PORTS];
    logic [N_PORTS-1:0] arb_grant;
    logic [PORT_W-1:0]  arb_idx;
    logic               q_full, q_empty, q_push, q_pop;
    logic [ENTRY_W-1:0] q_head;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_unpack
        assign req_payload[p] = up_req_data[p*DATA_W +: DATA_W];
    end

    rs_rr_arbiter #(.N_REQ(N_PORTS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (up_req_valid),
        .advance   (!q_full),
        .grant     (arb_grant),
        .grant_idx (arb_idx)
    );

    assign up_req_ready = q_full ? '0 : arb_grant;
    assign q_push       = (|up_req_valid) && !q_full;

    rs_req_fifo #(.WIDTH(ENTRY_W), .DEPTH(Q_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({arb_idx, req_payload[arb_idx]}),
        .pop       (q_pop),
        .head_data (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // routing table
    logic [SLOTS-1:0]  slot_busy;
    logic [PORT_W-1:0] rsp_port;
    logic [SEQ_W-1:0]  seq_q, seq_nx;
    logic              dn_fire, rsp_fire;
    logic [PORT_W-1:0] hold_port_q;
    logic [DATA_W-1:0] hold_data_q;

    assign seq_nx  = seq_q + 1'b1;
    assign dn_fire = dn_req_valid && dn_req_ready;

    rs_route_table #(.PORT_W(PORT_W), .SEQ_W(SEQ_W)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (dn_fire),
        .alloc_seq   (seq_q),
        .alloc_port  (hold_port_q),
        .release_en  (rsp_fire),
        .release_seq (dn_rsp_tag[SEQ_W-1:0]),
        .lookup_seq  (dn_rsp_tag[SEQ_W-1:0]),
        .lookup_port (rsp_port),
        .busy        (slot_busy)
    );

    // forwarding state machine
    fwd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        q_pop   = 1'b0;
        unique case (state_q)
            FWD_IDLE: begin
                if (!q_empty) begin
                    if (!slot_busy[seq_q]) begin
                        q_pop   = 1'b1;
                        state_d = FWD_ISSUE;
                    end else begin
                        state_d = FWD_BLOCKED;
                    end
                end
            end
            FWD_BLOCKED: begin
                if (q_empty) begin
                    state_d = FWD_IDLE;
                end else if (!slot_busy[seq_q]) begin
                    q_pop   = 1'b1;
                    state_d = FWD_ISSUE;
                end
            end
            FWD_ISSUE: begin
                if (dn_req_ready) begin
                    if (!q_empty && !slot_busy[seq_nx]) begin
                        q_pop   = 1'b1;
                        state_d = FWD_ISSUE;
                    end else if (!q_empty) begin
                        state_d = FWD_BLOCKED;
                    end else begin
                        state_d = FWD_IDLE;
                    end
                end
            end
            default: state_d = FWD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FWD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            hold_port_q <= '0;
            hold_data_q <= '0;
        end else begin
            if (dn_fire) begin
                seq_q <= seq_nx;
            end
            if (q_pop) begin
                hold_port_q <= q_head[ENTRY_W-1:DATA_W];
                hold_data_q <= q_head[DATA_W-1:0];
            end
        end
    end

    always_comb begin
        dn_req_valid = (state_q == FWD_ISSUE);
        dn_req_data  = hold_data_q;
        dn_req_tag   = {hold_port_q, seq_q};
    end

    // response routing
    for (genvar p = 0; p < N_PORTS; p++) begin : g_rsp
        assign up_rsp_valid[p] = dn_rsp_valid && (rsp_port == PORT_W'(p));
    end

    assign up_rsp_data  = dn_rsp_data;
    assign dn_rsp_ready = dn_rsp_valid && up_rsp_ready[rsp_port];
    assign rsp_fire     = dn_rsp_valid && dn_rsp_ready;

    // R5: held request stays put until accepted
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=>
            (dn_req_valid && $stable(dn_req_data) && $stable(dn_req_tag)));
    // R7: sequence field steps by one per downstream handshake
    p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_fire |=> (dn_req_tag[SEQ_W-1:0] == $past(dn_req_tag[SEQ_W-1:0]) + 1'b1));
    // R8: a response lights exactly one upstream port, the one its tag names
    p_rsp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rsp_valid |-> ($onehot(up_rsp_valid) && (rsp_port == dn_rsp_tag[TAG_W-1:SEQ_W])));
    // R1/R6: nothing presented downstream in the cycle after reset
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dn_req_valid);

endmodule

// File: tb/test_req_serializer.sv
`timescale 1ns/100ps
module test_req_serializer;

    localparam int NP = 4;
    localparam int DW = 32;
    localparam int SW = 3;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NP-1:0]  upv = '0;
    logic [DW-1:0]  upd [NP];
    logic [NP-1:0]  up_req_ready, up_rsp_valid;
    logic [DW-1:0]  up_rsp_data;
    logic [NP-1:0]  urr = '1;
    logic           dn_req_valid, dn_rsp_ready;
    logic [DW-1:0]  dn_req_data;
    logic [TW-1:0]  dn_req_tag;
    logic           dn_rdy = 1'b0;
    logic           rsv = 1'b0;
    logic [DW-1:0]  rsd = '0;
    logic [TW-1:0]  rst_tag = '0;

    req_serializer i_req_serializer (
        .clk(clk), .rst_n(rst_n),
        .up_req_valid(upv), .up_req_data({upd[3], upd[2], upd[1], upd[0]}),
        .up_req_ready(up_req_ready), .up_rsp_valid(up_rsp_valid),
        .up_rsp_data(up_rsp_data), .up_rsp_ready(urr),
        .dn_req_valid(dn_req_valid), .dn_req_data(dn_req_data),
        .dn_req_tag(dn_req_tag), .dn_req_ready(dn_rdy),
        .dn_rsp_valid(rsv), .dn_rsp_data(rsd), .dn_rsp_tag(rst_tag),
        .dn_rsp_ready(dn_rsp_ready)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard state
    int            exp_port [$];
    logic [DW-1:0] exp_data [$];
    int            acc_log  [$];
    logic [TW-1:0] out_tags [$];
    int            seqport  [8];
    bit            busy_tb  [8];
    bit            accflag  [NP];
    int            acc_total = 0;
    int            fwd_count = 0;
    int            rsp_count = 0;
    int            exp_seq   = 0;
    int            dcount    = 0;
    bit            rsp_en    = 1'b0;
    bit            rsp_done  = 1'b0;
    logic          pv = 1'b0, pr = 1'b0;
    logic [DW-1:0] pd = '0;
    logic [TW-1:0] pt = '0;

    initial for (int p = 0; p < NP; p++) begin upd[p] = '0; accflag[p] = 0; end
    initial for (int s = 0; s < 8; s++) begin busy_tb[s] = 0; seqport[s] = 0; end

    task automatic raise(input int p);
        dcount++;
        upd[p] = 32'hA000_0000 | (p << 12) | dcount;
        upv[p] = 1'b1;
    endtask

    // upstream monitor: records accepts (scoreboard push)
    always @(negedge clk) if (rst_n) begin
        if ((upv & up_req_ready) != '0)
            chk($countones(upv & up_req_ready) == 1, "R3 one accept per cycle",
                64'(upv & up_req_ready), 64'h1);
        for (int p = 0; p < NP; p++) begin
            if (upv[p] && up_req_ready[p]) begin
                exp_port.push_back(p);
                exp_data.push_back(upd[p]);
                acc_log.push_back(p);
                acc_total++;
                accflag[p] = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        for (int p = 0; p < NP; p++) if (accflag[p]) begin upv[p] = 1'b0; accflag[p] = 1'b0; end
    end

    // downstream request monitor: pops and compares
    always @(negedge clk) if (rst_n) begin
        if (pv && !pr) begin
            chk(dn_req_valid && dn_req_data == pd && dn_req_tag == pt, "R5 held request stable",
                {dn_req_data, 27'd0, dn_req_tag}, {pd, 27'd0, pt});
        end
        if (dn_req_valid && dn_rdy) begin
            int ep;
            logic [DW-1:0] ed;
            ep = (exp_port.size() > 0) ? exp_port.pop_front() : -1;
            ed = (exp_data.size() > 0) ? exp_data.pop_front() : '0;
            chk(dn_req_data == ed, "R6 order/payload", 64'(dn_req_data), 64'(ed));
            chk(int'(dn_req_tag[TW-1:SW]) == ep, "R7 tag port field", 64'(dn_req_tag[TW-1:SW]), 64'(ep));
            chk(int'(dn_req_tag[SW-1:0]) == exp_seq, "R7 tag sequence", 64'(dn_req_tag[SW-1:0]), 64'(exp_seq));
            chk(!busy_tb[dn_req_tag[SW-1:0]], "R9 slot free when reused", 64'(busy_tb[dn_req_tag[SW-1:0]]), 64'h0);
            busy_tb[dn_req_tag[SW-1:0]] = 1'b1;
            seqport[dn_req_tag[SW-1:0]] = ep;
            out_tags.push_back(dn_req_tag);
            exp_seq = (exp_seq + 1) % 8;
            fwd_count++;
        end
        pv = dn_req_valid; pr = dn_rdy; pd = dn_req_data; pt = dn_req_tag;
    end

    // downstream responder (newest outstanding first)
    always @(posedge clk) begin
        #1;
        if (rsp_done) begin rsv = 1'b0; rsp_done = 1'b0; end
        if (!rsv && rsp_en && out_tags.size() > 0) begin
            rst_tag = out_tags.pop_back();
            rsd = 32'h5500_0000 | rst_tag;
            rsv = 1'b1;
        end
    end

    always @(negedge clk) if (rst_n && rsv) begin
        int xp;
        xp = seqport[rst_tag[SW-1:0]];
        chk(up_rsp_valid == NP'(1 << xp), "R8 routed port", 64'(up_rsp_valid), 64'(1 << xp));
        chk(up_rsp_data == rsd, "R8 response data", 64'(up_rsp_data), 64'(rsd));
        chk(dn_rsp_ready == urr[xp], "R8 accept passthrough", 64'(dn_rsp_ready), 64'(urr[xp]));
        if (dn_rsp_ready) begin
            busy_tb[rst_tag[SW-1:0]] = 1'b0;
            rsp_count++;
            rsp_done = 1'b1;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", rsp_count, 13);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!dn_req_valid, "R1 dn_req_valid after reset", 64'(dn_req_valid), 64'h0);
        chk(up_rsp_valid == '0, "R1 up_rsp_valid after reset", 64'(up_rsp_valid), 64'h0);
        chk(up_req_ready == '0, "R1 up_req_ready idle", 64'(up_req_ready), 64'h0);

        // R2: single request from port 2, latency
        @(posedge clk); #2 raise(2);
        @(negedge clk);                       // accept edge follows
        chk(up_req_ready == 4'b0100, "R2 port 2 accepted", 64'(up_req_ready), 64'h4);
        @(negedge clk);
        chk(!dn_req_valid, "R2 not yet forwarded", 64'(dn_req_valid), 64'h0);
        @(negedge clk);
        chk(dn_req_valid && dn_req_tag == 5'b10_000, "R2 forwarded one cycle later",
            {63'd0, dn_req_valid}, 64'h1);

        // R3: all four together; pointer sits after port 2, so 3,0,1,2
        @(posedge clk); #2 for (int p = 0; p < NP; p++) raise(p);
        wait (acc_total == 5);
        @(negedge clk);
        chk(acc_log[1] == 3 && acc_log[2] == 0 && acc_log[3] == 1 && acc_log[4] == 2,
            "R3 round-robin order", 64'(acc_log[1]), 64'h3);
        // R3: ports 0 and 2; 0 wins, then a returning 0 must wait behind 2
        @(posedge clk); #2 begin raise(0); raise(2); end
        wait (acc_total == 6);
        @(posedge clk); #2 raise(0);
        wait (acc_total == 8);
        @(negedge clk);
        chk(acc_log[5] == 0 && acc_log[6] == 2 && acc_log[7] == 0, "R3 fairness after regrant",
            64'(acc_log[6]), 64'h2);

        // R4: saturate with the responder stalled
        for (int c = 0; c < 20; c++) begin
            @(posedge clk); #2;
            for (int p = 0; p < NP; p++) if (!upv[p]) raise(p);
        end
        @(negedge clk);
        chk(acc_total == 9, "R4 capacity 8 + holding", 64'(acc_total), 64'd9);
        chk(upv == 4'hF && up_req_ready == '0, "R4 no accept when full", 64'(up_req_ready), 64'h0);

        // R6/R9: release downstream, no responses yet
        @(posedge clk); #2 dn_rdy = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(fwd_count == 8, "R9 eight outstanding then stop", 64'(fwd_count), 64'd8);
        chk(!dn_req_valid, "R9 blocked on busy slot", 64'(dn_req_valid), 64'h0);

        // R8: responses newest first, port 2 stalls for a while
        @(posedge clk); #2 begin rsp_en = 1'b1; urr = 4'b1011; end
        repeat (10) @(posedge clk);
        #2 urr = 4'hF;
        wait (rsp_count == 13);
        @(negedge clk);
        chk(fwd_count == 13 && acc_total == 13, "R6 all requests forwarded", 64'(fwd_count), 64'd13);
        chk(exp_port.size() == 0, "R6 scoreboard drained", 64'(exp_port.size()), 64'h0);
        chk(up_rsp_valid == '0 && !dn_req_valid, "R1 quiet at end", 64'(up_rsp_valid), 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule